// File: doc/BRIEF.md
# I2C Message Sequencer

The sequencer turns a chain of message descriptors into the byte-level command stream that a simple I2C master core understands. Each descriptor carries a target address, a flag for 10-bit addressing, a read flag, a flag that suppresses the address phase and a byte count. Bytes to transmit come in on a valid/ready stream, and received bytes leave on a valid-strobed stream. The sequencer waits for a free bus and issues the address phase or phases. It then moves the data bytes, links messages either with a repeated START or seamlessly, and closes the transfer with STOP followed by an interrupt acknowledge.

The core is driven through one registered command strobe with per-action bits and a transmit byte. The core reports transfer-in-progress, bus-busy, NACK and lost-arbitration flags. The core must raise transfer-in-progress on the clock edge at which it samples a command that is not an interrupt acknowledge. The sequencer finishes every transfer with a one-cycle done or error pulse carrying a 2-bit cause. A progress watchdog, measured in clock cycles, aborts a transfer that stops advancing.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: No command is issued in the cycle after one in which the core reports transfer-in-progress. A new command is never issued in the cycle right after another command.
- R2: After a descriptor is accepted, no command is issued while the core reports bus-busy. The first command follows once busy clears.
- R3: A 7-bit address phase is a command with start and write set, carrying the byte {address[6:0], read flag}.
- R4: A 10-bit address phase is two commands. The first has start and write set and carries {5'b11110, address[9:8], read flag}. The second is a plain write carrying address[7:0].
- R5: A NACK seen after an address or data byte produces a STOP command and then an error with cause code 1.
- R6: Lost arbitration during an active transfer produces a STOP command and then an error with cause code 2.
- R7: Read commands set the nack bit only for the final byte of a message. Each received byte is delivered on the read stream in order.
- R8: When a message ends and another follows, the next message gets a fresh address phase. If the next message has its no-restart flag set, its data continue with no address phase.
- R9: After the final byte of the last message, a STOP command is issued. Once it completes, an interrupt-acknowledge command is issued together with a done pulse carrying cause code 0.
- R10: If no step succeeds for TIMEOUT_CYC consecutive cycles, the transfer ends with an error of cause code 3. Every successful step restarts this count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msgValid | input | 1 | Descriptor offered |
| msgReady | output | 1 | Descriptor taken this cycle |
| msgAddr | input | 10 | Target address |
| msgTen | input | 1 | Use 10-bit addressing |
| msgRead | input | 1 | Message reads from the target |
| msgNoStart | input | 1 | Continue with no address phase |
| msgLast | input | 1 | Final message of the transfer |
| msgLen | input | LEN_W | Byte count of the message |
| wrValid | input | 1 | Transmit byte offered |
| wrReady | output | 1 | Transmit byte taken this cycle |
| wrData | input | 8 | Transmit byte |
| rdValid | output | 1 | Received byte strobe |
| rdData | output | 8 | Received byte |
| coreCmdValid | output | 1 | Command strobe to the core |
| coreCmdStart | output | 1 | Generate START |
| coreCmdStop | output | 1 | Generate STOP |
| coreCmdRead | output | 1 | Read one byte |
| coreCmdWrite | output | 1 | Write coreTxByte |
| coreCmdNack | output | 1 | Answer the read byte with NACK |
| coreCmdIack | output | 1 | Acknowledge the core interrupt |
| coreTxByte | output | 8 | Byte to transmit |
| coreRxByte | input | 8 | Byte last received by the core |
| coreTip | input | 1 | Core transfer in progress |
| coreBusy | input | 1 | Bus held by some master |
| coreNack | input | 1 | Last byte was not acknowledged |
| coreArbLost | input | 1 | Arbitration was lost |
| seqActive | output | 1 | A transfer is under way |
| seqDone | output | 1 | Transfer completed pulse |
| seqError | output | 1 | Transfer failed pulse |
| seqErrCode | output | 2 | Cause: 0 none, 1 no device, 2 arbitration, 3 timeout |

## Verification
The bench targets the address-byte arithmetic for both address widths. A wrong shift or field placement would show up as a bad transmit byte on the first or second address command. It also covers both ways of joining messages: a design that ignored the no-restart flag would insert an extra START, and one that dropped the address phase would merge the messages. Read chains are checked for the nack bit landing on exactly the last byte, since placing it one byte early or late ends the transfer wrongly. The bench also covers the watchdog from both sides: a held bus must time out with no command issued, while slow but steady byte steps whose total exceeds the timeout must still finish. A counter that did not restart on each step would abort those slow transfers.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DONE, S_INIT, S_ADDR, S_ADDR10,
    S_START, S_WRITE, S_READ, S_ERROR
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_NODEV   = 2'd1,
    ERR_ARB     = 2'd2,
    ERR_TIMEOUT = 2'd3
  } err_code_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr1;
    logic loadAddr2;
    logic loadWr;
    logic capRx;
  } dp_strobe_t;

  typedef struct packed {
    logic valid;
    logic start;
    logic stop;
    logic read;
    logic write;
    logic nack;
    logic iack;
  } core_cmd_t;

endpackage

// File: rtl/i2c_seq_datapath.sv
module i2c_seq_datapath
  import i2c_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dp_strobe_t stb,
  input  logic [9:0] descAddr,
  input  logic       descTen,
  input  logic       descRead,
  input  logic [7:0] wrData,
  input  logic [7:0] coreRxByte,
  output logic [7:0] coreTxByte,
  output logic       rdValid,
  output logic [7:0] rdData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreTxByte <= '0;
      rdValid    <= 1'b0;
      rdData     <= '0;
    end else begin
      if (stb.loadAddr1) begin
        if (descTen) coreTxByte <= {5'b11110, descAddr[9:8], descRead};
        else         coreTxByte <= {descAddr[6:0], descRead};
      end else if (stb.loadAddr2) begin
        coreTxByte <= descAddr[7:0];
      end else if (stb.loadWr) begin
        coreTxByte <= wrData;
      end
      rdValid <= stb.capRx;
      if (stb.capRx) rdData <= coreRxByte;
    end
  end

  AST_TX_SOURCE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadAddr1, stb.loadAddr2, stb.loadWr})); // R4

endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  output logic             msgReady,
  input  logic [9:0]       msgAddr,
  input  logic             msgTen,
  input  logic             msgRead,
  input  logic             msgNoStart,
  input  logic             msgLast,
  input  logic [LEN_W-1:0] msgLen,
  input  logic             wrValid,
  output logic             wrReady,
  input  logic             coreTip,
  input  logic             coreBusy,
  input  logic             coreNack,
  input  logic             coreArbLost,
  output core_cmd_t        cmd,
  output dp_strobe_t       stb,
  output logic [9:0]       descAddr,
  output logic             descTen,
  output logic             descRead,
  output logic             seqActive,
  output logic             seqDone,
  output logic             seqError,
  output logic [1:0]       seqErrCode
);

  localparam int WD_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT_CYC - 1);

  seq_state_e       st, stN;
  err_code_e        errQ, errN;
  logic             lastR;
  logic [LEN_W-1:0] lenR, pos, posN;
  logic [WD_W-1:0]  wd;
  core_cmd_t        cmdN;
  logic             loadDesc, step, canStep, doneN, failN, timeoutHit;
  logic             isRd, endMsg, needDesc, curRd;
  logic [LEN_W:0]   pos1;
  logic [LEN_W-1:0] curLen, curPos;

  always_comb begin
    stN      = st;
    posN     = pos;
    errN     = errQ;
    cmdN     = '0;
    stb      = '0;
    loadDesc = 1'b0;
    msgReady = 1'b0;
    wrReady  = 1'b0;
    step     = 1'b0;
    doneN    = 1'b0;
    failN    = 1'b0;
    canStep  = (st != S_IDLE) && !cmd.valid && !coreTip;
    isRd     = (st == S_READ);
    pos1     = {1'b0, pos} + (LEN_W+1)'(isRd);
    endMsg   = pos1 >= {1'b0, lenR};
    needDesc = endMsg && !lastR;
    curRd    = needDesc ? msgRead : descRead;
    curLen   = needDesc ? msgLen : lenR;
    curPos   = needDesc ? '0 : pos1[LEN_W-1:0];

    case (st)
      S_IDLE: begin
        if (msgValid) begin
          msgReady = 1'b1;
          loadDesc = 1'b1;
          posN     = '0;
          errN     = ERR_NONE;
          stN      = S_INIT;
        end
      end
      S_DONE, S_ERROR: begin
        if (canStep) begin
          cmdN.valid = 1'b1;
          cmdN.iack  = 1'b1;
          step       = 1'b1;
          doneN      = (st == S_DONE);
          failN      = (st == S_ERROR);
          stN        = S_IDLE;
        end
      end
      default: begin
        if (canStep) begin
          if (coreArbLost) begin
            cmdN.valid = 1'b1;
            cmdN.stop  = 1'b1;
            errN       = ERR_ARB;
            stN        = S_ERROR;
            step       = 1'b1;
          end else if (st == S_INIT && coreBusy) begin
            // bus held elsewhere: no step
          end else if (st == S_INIT || st == S_ADDR) begin
            cmdN.valid     = 1'b1;
            cmdN.start     = 1'b1;
            cmdN.write     = 1'b1;
            stb.loadAddr1  = 1'b1;
            stN            = descTen ? S_ADDR10 : S_START;
            step           = 1'b1;
          end else if (st == S_ADDR10) begin
            cmdN.valid     = 1'b1;
            cmdN.write     = 1'b1;
            stb.loadAddr2  = 1'b1;
            stN            = S_START;
            step           = 1'b1;
          end else if ((st == S_START || st == S_WRITE) && coreNack) begin
            cmdN.valid = 1'b1;
            cmdN.stop  = 1'b1;
            errN       = ERR_NODEV;
            stN        = S_ERROR;
            step       = 1'b1;
          end else if (endMsg && lastR) begin
            stb.capRx  = isRd;
            cmdN.valid = 1'b1;
            cmdN.stop  = 1'b1;
            stN        = S_DONE;
            step       = 1'b1;
          end else if (needDesc && !msgValid) begin
            // next descriptor not yet offered: stall
          end else if (needDesc && !msgNoStart) begin
            stb.capRx = isRd;
            loadDesc  = 1'b1;
            msgReady  = 1'b1;
            posN      = '0;
            stN       = S_ADDR;
            step      = 1'b1;
          end else if (curRd) begin
            stb.capRx  = isRd;
            loadDesc   = needDesc;
            msgReady   = needDesc;
            cmdN.valid = 1'b1;
            cmdN.read  = 1'b1;
            cmdN.nack  = (curPos == curLen - LEN_W'(1));
            posN       = curPos;
            stN        = S_READ;
            step       = 1'b1;
          end else if (wrValid) begin
            stb.capRx  = isRd;
            stb.loadWr = 1'b1;
            wrReady    = 1'b1;
            loadDesc   = needDesc;
            msgReady   = needDesc;
            cmdN.valid = 1'b1;
            cmdN.write = 1'b1;
            posN       = curPos + LEN_W'(1);
            stN        = S_WRITE;
            step       = 1'b1;
          end
        end
      end
    endcase
  end

  assign timeoutHit = (st != S_IDLE) && !step && (wd == WD_LAST);
  assign seqActive  = (st != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= S_IDLE;
      errQ       <= ERR_NONE;
      pos        <= '0;
      wd         <= '0;
      cmd        <= '0;
      seqDone    <= 1'b0;
      seqError   <= 1'b0;
      seqErrCode <= 2'd0;
      descAddr   <= '0;
      descTen    <= 1'b0;
      descRead   <= 1'b0;
      lastR      <= 1'b0;
      lenR       <= '0;
    end else begin
      cmd     <= cmdN;
      seqDone <= doneN;
      if (timeoutHit) begin
        st         <= S_IDLE;
        wd         <= '0;
        seqError   <= 1'b1;
        seqErrCode <= ERR_TIMEOUT;
      end else begin
        st         <= stN;
        pos        <= posN;
        errQ       <= errN;
        seqError   <= failN;
        seqErrCode <= failN ? errQ : ERR_NONE;
        wd         <= (st == S_IDLE || step) ? '0 : wd + WD_W'(1);
      end
      if (loadDesc) begin
        descAddr <= msgAddr;
        descTen  <= msgTen;
        descRead <= msgRead;
        lastR    <= msgLast;
        lenR     <= msgLen;
      end
    end
  end

  AST_NO_STEP_IN_TIP: assert property (@(posedge clk) disable iff (!rstN)
    coreTip |=> !cmd.valid); // R1

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_INIT && coreBusy && !coreArbLost) |=> !cmd.valid); // R2

  AST_NACK_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (canStep && (st == S_START || st == S_WRITE) && coreNack && !coreArbLost)
      |=> (cmd.stop && st == S_ERROR && errQ == ERR_NODEV)); // R5

  AST_ARB_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (canStep && coreArbLost && st != S_DONE && st != S_ERROR)
      |=> (cmd.stop && st == S_ERROR && errQ == ERR_ARB)); // R6

  AST_DONE_WITH_IACK: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (cmd.valid && cmd.iack && seqErrCode == 2'd0 && !seqError)); // R9

endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  output logic             msgReady,
  input  logic [9:0]       msgAddr,
  input  logic             msgTen,
  input  logic             msgRead,
  input  logic             msgNoStart,
  input  logic             msgLast,
  input  logic [LEN_W-1:0] msgLen,
  input  logic             wrValid,
  output logic             wrReady,
  input  logic [7:0]       wrData,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             coreCmdValid,
  output logic             coreCmdStart,
  output logic             coreCmdStop,
  output logic             coreCmdRead,
  output logic             coreCmdWrite,
  output logic             coreCmdNack,
  output logic             coreCmdIack,
  output logic [7:0]       coreTxByte,
  input  logic [7:0]       coreRxByte,
  input  logic             coreTip,
  input  logic             coreBusy,
  input  logic             coreNack,
  input  logic             coreArbLost,
  output logic             seqActive,
  output logic             seqDone,
  output logic             seqError,
  output logic [1:0]       seqErrCode
);

  core_cmd_t  cmd;
  dp_strobe_t stb;
  logic [9:0] descAddr;
  logic       descTen, descRead;

  i2c_seq_ctrl #(.LEN_W(LEN_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .msgValid(msgValid), .msgReady(msgReady), .msgAddr(msgAddr),
    .msgTen(msgTen), .msgRead(msgRead), .msgNoStart(msgNoStart),
    .msgLast(msgLast), .msgLen(msgLen),
    .wrValid(wrValid), .wrReady(wrReady),
    .coreTip(coreTip), .coreBusy(coreBusy), .coreNack(coreNack),
    .coreArbLost(coreArbLost),
    .cmd(cmd), .stb(stb),
    .descAddr(descAddr), .descTen(descTen), .descRead(descRead),
    .seqActive(seqActive), .seqDone(seqDone), .seqError(seqError),
    .seqErrCode(seqErrCode)
  );

  i2c_seq_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .descAddr(descAddr), .descTen(descTen), .descRead(descRead),
    .wrData(wrData), .coreRxByte(coreRxByte),
    .coreTxByte(coreTxByte), .rdValid(rdValid), .rdData(rdData)
  );

  assign coreCmdValid = cmd.valid;
  assign coreCmdStart = cmd.start;
  assign coreCmdStop  = cmd.stop;
  assign coreCmdRead  = cmd.read;
  assign coreCmdWrite = cmd.write;
  assign coreCmdNack  = cmd.nack;
  assign coreCmdIack  = cmd.iack;

endmodule

// File: tb/i2c_msg_sequencer_bench.sv
module i2c_msg_sequencer_bench;

  localparam int TOUT = 64;
  // command flag codes {start,stop,read,write,nack,iack}
  localparam logic [5:0] C_STW  = 6'b100100;
  localparam logic [5:0] C_W    = 6'b000100;
  localparam logic [5:0] C_R    = 6'b001000;
  localparam logic [5:0] C_RN   = 6'b001010;
  localparam logic [5:0] C_STOP = 6'b010000;
  localparam logic [5:0] C_IACK = 6'b000001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic       msgValid, msgReady, msgTen, msgRead, msgNoStart, msgLast;
  logic [9:0] msgAddr;
  logic [7:0] msgLen;
  logic       wrValid, wrReady, rdValid;
  logic [7:0] wrData, rdData, coreTxByte;
  logic [7:0] coreRxByte = 8'h00;
  logic       coreCmdValid, coreCmdStart, coreCmdStop, coreCmdRead;
  logic       coreCmdWrite, coreCmdNack, coreCmdIack;
  logic       coreTip, seqActive, seqDone, seqError;
  logic [1:0] seqErrCode;
  logic       busyVal = 1'b0, nackVal = 1'b0, arbVal = 1'b0;

  // stimulus storage
  logic [9:0] dAddr [0:7];
  logic       dTen [0:7], dRd [0:7], dNs [0:7], dLast [0:7];
  logic [7:0] dLen [0:7];
  logic [7:0] wrArr [0:15];
  int descN = 0, wrN = 0, descIdx = 0, wrIdx = 0;
  int tipLen = 8, tipCnt = 0, rdIdx = 0;

  // observation logs
  logic [5:0] cmdLog [0:31];
  logic [7:0] txLog [0:31];
  logic [7:0] rdLog [0:15];
  int nCmd = 0, nRd = 0;
  logic gotDone = 1'b0, gotErr = 1'b0;
  logic [1:0] gotCode = 2'd0;

  int nTests = 0, nFail = 0;
  logic timedOut = 1'b0;

  assign msgValid   = rstN && (descIdx < descN);
  assign msgAddr    = dAddr[descIdx[2:0]];
  assign msgTen     = dTen[descIdx[2:0]];
  assign msgRead    = dRd[descIdx[2:0]];
  assign msgNoStart = dNs[descIdx[2:0]];
  assign msgLast    = dLast[descIdx[2:0]];
  assign msgLen     = dLen[descIdx[2:0]];
  assign wrValid    = rstN && (wrIdx < wrN);
  assign wrData     = wrArr[wrIdx[3:0]];
  assign coreTip    = (tipCnt != 0);

  i2c_msg_sequencer #(.LEN_W(8), .TIMEOUT_CYC(TOUT)) u_i2c_msg_sequencer (
    .clk(clk), .rstN(rstN),
    .msgValid(msgValid), .msgReady(msgReady), .msgAddr(msgAddr),
    .msgTen(msgTen), .msgRead(msgRead), .msgNoStart(msgNoStart),
    .msgLast(msgLast), .msgLen(msgLen),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdData(rdData),
    .coreCmdValid(coreCmdValid), .coreCmdStart(coreCmdStart),
    .coreCmdStop(coreCmdStop), .coreCmdRead(coreCmdRead),
    .coreCmdWrite(coreCmdWrite), .coreCmdNack(coreCmdNack),
    .coreCmdIack(coreCmdIack), .coreTxByte(coreTxByte),
    .coreRxByte(coreRxByte), .coreTip(coreTip), .coreBusy(busyVal),
    .coreNack(nackVal), .coreArbLost(arbVal),
    .seqActive(seqActive), .seqDone(seqDone), .seqError(seqError),
    .seqErrCode(seqErrCode)
  );

  // simple core model and stream feeders
  always @(posedge clk) begin
    if (!rstN) begin
      tipCnt <= 0; rdIdx <= 0; descIdx <= 0; wrIdx <= 0;
    end else begin
      if (coreCmdValid && !coreCmdIack) tipCnt <= tipLen;
      else if (tipCnt != 0) tipCnt <= tipCnt - 1;
      if (coreCmdValid && coreCmdRead) begin
        coreRxByte <= 8'hC0 + 8'(rdIdx);
        rdIdx <= rdIdx + 1;
      end
      if (msgValid && msgReady) descIdx <= descIdx + 1;
      if (wrValid && wrReady) wrIdx <= wrIdx + 1;
    end
  end

  // monitor away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      nCmd = 0; nRd = 0; gotDone = 1'b0; gotErr = 1'b0; gotCode = 2'd0;
    end else begin
      if (coreCmdValid && nCmd < 32) begin
        cmdLog[nCmd] = {coreCmdStart, coreCmdStop, coreCmdRead,
                        coreCmdWrite, coreCmdNack, coreCmdIack};
        txLog[nCmd]  = coreTxByte;
        nCmd = nCmd + 1;
      end
      if (rdValid && nRd < 16) begin
        rdLog[nRd] = rdData;
        nRd = nRd + 1;
      end
      if (seqDone) gotDone = 1'b1;
      if (seqError) begin gotErr = 1'b1; gotCode = seqErrCode; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectCmd(input int i, input logic [5:0] f, input logic [7:0] tx,
                           input string tag);
    chk(cmdLog[i] == f, tag, 32'(cmdLog[i]), 32'(f));
    if (f[2]) chk(txLog[i] == tx, tag, 32'(txLog[i]), 32'(tx));
  endtask

  task automatic doReset();
    rstN = 1'b0; descN = 0; wrN = 0;
    busyVal = 1'b0; nackVal = 1'b0; arbVal = 1'b0; tipLen = 8;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic setDesc(input int i, input logic [9:0] a, input logic ten,
                         input logic rd, input logic ns, input logic last,
                         input logic [7:0] len);
    dAddr[i] = a; dTen[i] = ten; dRd[i] = rd; dNs[i] = ns;
    dLast[i] = last; dLen[i] = len;
  endtask

  task automatic runWait();
    for (int c = 0; c < 3000 && !(gotDone || gotErr); c++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    chk(!coreCmdValid && !seqActive && !seqDone && !seqError && !msgReady,
        "reset idle outputs", {coreCmdValid, seqActive, seqDone, seqError}, 0);
  endtask

  task automatic testWrite7();
    doReset();
    setDesc(0, 10'h050, 0, 0, 0, 1, 8'd2);
    wrArr[0] = 8'h3C; wrArr[1] = 8'h9E; wrN = 2;
    descN = 1;
    runWait();
    chk(nCmd == 5, "R9 write7 command count", nCmd, 5);
    expectCmd(0, C_STW, 8'hA0, "R3 7-bit write address byte");
    expectCmd(1, C_W, 8'h3C, "R3 write data 0");
    expectCmd(2, C_W, 8'h9E, "R3 write data 1");
    expectCmd(3, C_STOP, 8'h00, "R9 stop after last byte");
    expectCmd(4, C_IACK, 8'h00, "R9 iack after stop");
    chk(gotDone && !gotErr, "R9 done pulse", {gotDone, gotErr}, 2'b10);
  endtask

  task automatic testRead7();
    doReset();
    setDesc(0, 10'h021, 0, 1, 0, 1, 8'd3);
    descN = 1;
    runWait();
    chk(nCmd == 6, "R7 read command count", nCmd, 6);
    expectCmd(0, C_STW, 8'h43, "R3 7-bit read address byte");
    expectCmd(1, C_R, 8'h00, "R7 first read acks");
    expectCmd(2, C_R, 8'h00, "R7 middle read acks");
    expectCmd(3, C_RN, 8'h00, "R7 last read nacks");
    expectCmd(4, C_STOP, 8'h00, "R9 stop after read");
    chk(nRd == 3, "R7 read byte count", nRd, 3);
    for (int k = 0; k < 3; k++)
      chk(rdLog[k] == 8'hC0 + 8'(k), "R7 read byte order", rdLog[k], 8'hC0 + k);
    chk(gotDone && gotCode == 2'd0, "R9 read done code", gotCode, 0);
  endtask

  task automatic testTenBit();
    doReset();
    setDesc(0, 10'h2A5, 1, 0, 0, 1, 8'd1);
    wrArr[0] = 8'h5A; wrN = 1;
    descN = 1;
    runWait();
    chk(nCmd == 5, "R4 ten-bit command count", nCmd, 5);
    expectCmd(0, C_STW, 8'hF4, "R4 ten-bit first byte");
    expectCmd(1, C_W, 8'hA5, "R4 ten-bit second byte");
    expectCmd(2, C_W, 8'h5A, "R4 ten-bit data");
    expectCmd(3, C_STOP, 8'h00, "R9 ten-bit stop");
  endtask

  task automatic testRestartChain();
    doReset();
    setDesc(0, 10'h050, 0, 0, 0, 0, 8'd1);
    setDesc(1, 10'h050, 0, 1, 0, 1, 8'd2);
    wrArr[0] = 8'h11; wrN = 1;
    descN = 2;
    runWait();
    chk(nCmd == 7, "R8 restart chain count", nCmd, 7);
    expectCmd(0, C_STW, 8'hA0, "R8 first address");
    expectCmd(1, C_W, 8'h11, "R8 first data");
    expectCmd(2, C_STW, 8'hA1, "R8 repeated start address");
    expectCmd(3, C_R, 8'h00, "R7 chained read ack");
    expectCmd(4, C_RN, 8'h00, "R7 chained read nack");
    expectCmd(5, C_STOP, 8'h00, "R9 chain stop");
    chk(gotDone, "R8 chain done", gotDone, 1);
  endtask

  task automatic testNoStartChain();
    doReset();
    setDesc(0, 10'h050, 0, 0, 0, 0, 8'd1);
    setDesc(1, 10'h050, 0, 0, 1, 1, 8'd2);
    wrArr[0] = 8'h11; wrArr[1] = 8'h22; wrArr[2] = 8'h33; wrN = 3;
    descN = 2;
    runWait();
    chk(nCmd == 6, "R8 no-restart count", nCmd, 6);
    expectCmd(0, C_STW, 8'hA0, "R8 no-restart address");
    expectCmd(1, C_W, 8'h11, "R8 no-restart byte 0");
    expectCmd(2, C_W, 8'h22, "R8 no-restart byte 1");
    expectCmd(3, C_W, 8'h33, "R8 no-restart byte 2");
    expectCmd(4, C_STOP, 8'h00, "R8 no-restart stop");
  endtask

  task automatic testNack();
    doReset();
    nackVal = 1'b1;
    setDesc(0, 10'h050, 0, 0, 0, 1, 8'd2);
    wrArr[0] = 8'h3C; wrArr[1] = 8'h9E; wrN = 2;
    descN = 1;
    runWait();
    chk(nCmd == 3, "R5 nack command count", nCmd, 3);
    expectCmd(0, C_STW, 8'hA0, "R5 address before nack");
    expectCmd(1, C_STOP, 8'h00, "R5 stop after nack");
    expectCmd(2, C_IACK, 8'h00, "R5 iack after nack");
    chk(gotErr && !gotDone && gotCode == 2'd1, "R5 no-device code", gotCode, 1);
  endtask

  task automatic testArb();
    doReset();
    arbVal = 1'b1;
    setDesc(0, 10'h050, 0, 0, 0, 1, 8'd1);
    wrArr[0] = 8'h3C; wrN = 1;
    descN = 1;
    runWait();
    chk(nCmd == 2, "R6 arbitration command count", nCmd, 2);
    expectCmd(0, C_STOP, 8'h00, "R6 stop on arbitration loss");
    chk(gotErr && gotCode == 2'd2, "R6 arbitration code", gotCode, 2);
  endtask

  task automatic testBusyWait();
    doReset();
    busyVal = 1'b1;
    setDesc(0, 10'h050, 0, 0, 0, 1, 8'd1);
    wrArr[0] = 8'h77; wrN = 1;
    descN = 1;
    repeat (30) @(negedge clk);
    chk(nCmd == 0, "R2 no command while busy", nCmd, 0);
    busyVal = 1'b0;
    runWait();
    expectCmd(0, C_STW, 8'hA0, "R2 address once idle");
    chk(gotDone && !gotErr, "R2 completes after busy", {gotDone, gotErr}, 2'b10);
  endtask

  task automatic testTimeout();
    doReset();
    busyVal = 1'b1;
    setDesc(0, 10'h050, 0, 0, 0, 1, 8'd1);
    wrArr[0] = 8'h77; wrN = 1;
    descN = 1;
    runWait();
    chk(gotErr && gotCode == 2'd3, "R10 timeout code", gotCode, 3);
    chk(nCmd == 0, "R10 no command on timeout", nCmd, 0);
    chk(!seqActive, "R10 idle after timeout", seqActive, 0);
  endtask

  task automatic testWatchdogRestart();
    doReset();
    tipLen = 40;
    setDesc(0, 10'h050, 0, 0, 0, 1, 8'd3);
    wrArr[0] = 8'h01; wrArr[1] = 8'h02; wrArr[2] = 8'h03; wrN = 3;
    descN = 1;
    runWait();
    chk(gotDone && !gotErr, "R10 slow steps do not time out", {gotDone, gotErr}, 2'b10);
    chk(nCmd == 6, "R1 one command per completed step", nCmd, 6);
  endtask

  // R1: no command in the cycle after the core reports in-progress
  always @(negedge clk) begin
    if (rstN && $past(coreTip) && coreCmdValid && !$past(coreCmdValid)) begin
      nTests++;
      nFail++;
      $display("FAIL R1 command while in progress actual=1 expected=0");
    end
  end

  initial begin
    fork
      begin
        testReset();
        testWrite7();
        testRead7();
        testTenBit();
        testRestartChain();
        testNoStartChain();
        testNack();
        testArb();
        testBusyWait();
        testTimeout();
        testWatchdogRestart();
      end
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule